// File: doc/BRIEF.md
# Transmit FIFO Block Sequencer

This block steers writes into a 32-byte transmit FIFO that sits in front of an HDLC-style serial transmitter. It has two modes. In interrupt mode the processor refills the FIFO after a ready pulse, with a fixed allowance of writes per pulse. In DMA mode software first loads the frame length into a pair of count registers. It then issues a transmit command, and the sequencer asks a level-triggered DMA controller for one block at a time.

A frame is cut into as many full blocks as fit, each of 32 bytes (32 byte writes or 16 word writes), plus one short block for the bytes left over. A block is requested only when the FIFO has room for all of it. The request is withdrawn early enough that the controller ends exactly on the block's final write. When the whole count has been written, the sequencer raises a done flag and drops any further writes until the next command.

Bus writes may be 8 or 16 bits wide. In a 16-bit word, the low byte always goes out first. Serial shifting and framing belong to the transmitter, not to this block.

Top module: `txfifo_dma_seq`

## Requirements
- R1: After reset, dmaReq, readyIrq, done and fifoWe are all low.
- R2: The address map is as follows.
  - A bus write to any address 0x00 to 0x1F targets the FIFO tail.
  - Address 0x20 loads the count low byte from busData[7:0].
  - Address 0x21 loads the count high bits from busData[3:0].
  - A write to any other address is dropped.
  - Register writes never assert fifoWe.
- R3: Accepted FIFO writes are forwarded in the same cycle on fifoData, which is busData unchanged.
  - Byte mode (wordMode=0): fifoByteEn=2'b01.
  - Word mode: fifoByteEn=2'b11, with busData[7:0] as the first byte to be sent.
  - fifoByteEn[0] is always set on a write.
- R4: With dmaMode=0, readyIrq pulses for one cycle. The pulse comes in the cycle after fifoFree first reaches 32, and it grants 32 writes in byte mode or 16 in word mode. Writes beyond that allowance are dropped.
- R5: In DMA mode, a xmitCmd pulse starts a frame of the loaded byte count. The frame is served as n blocks of 32 bytes plus one block holding the remainder. A zero remainder adds no block.
- R6: A block request rises only when fifoFree is at least the block's byte count. It rises at the second clock edge after the command, or after the previous block's last write, provided space is available then. Otherwise it rises one edge after space appears.
- R7: Once a block is granted, after each accepted write dmaReq stays high only while two or more of that block's writes remain.
- R8: done is set at the edge of the frame's final write, or at the command edge for a zero count. While done is set, DMA-mode writes are dropped and dmaReq stays low until the next command.
- R9: In word mode with an odd count, the final write of the frame has fifoByteEn=2'b01.
- R10: In DMA mode, writes made while no block is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaMode | input | 1 | 1 selects DMA block transfers, 0 selects interrupt-driven refill |
| wordMode | input | 1 | 1 selects 16-bit bus writes, 0 selects 8-bit |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | 8 | Bus write address |
| busData | input | 16 | Bus write data, low byte first |
| xmitCmd | input | 1 | Transmit command pulse (DMA mode) |
| fifoFree | input | 6 | Free FIFO space in bytes, 0 to 32 |
| dmaReq | output | 1 | Level request to the DMA controller |
| readyIrq | output | 1 | One-cycle FIFO-ready interrupt (interrupt mode) |
| done | output | 1 | Whole preloaded frame written |
| fifoWe | output | 1 | FIFO write enable |
| fifoData | output | 16 | FIFO write data |
| fifoByteEn | output | 2 | Valid bytes of fifoData; bit 0 is the low byte |

## Verification
A corrupted remaining-byte counter shows up at the ports in one of three ways: a block with the wrong number of writes, a missing or extra request after the last block, or done arriving one write early or late. All of these appear within the frame in question. A wrong per-block write counter moves the fall of dmaReq by whole write cycles, so the bench samples the request after every single write rather than only at block ends. A bad interrupt allowance is caught on the 17th word write or the 33rd byte write after a ready pulse. A wrong address decode is caught on the first write, because fifoWe is combinational.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  // strobes from control to datapath for one bus cycle
  typedef struct packed {
    logic fwd;       // pass this bus write to the FIFO
    logic halfWord;  // only the low byte of this word is valid
  } seqStrobe_t;

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
#(
  parameter int FIFO_BYTES = 32,
  parameter int CNT_W      = 12,
  parameter int FREE_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaMode,
  input  logic              wordMode,
  input  logic              xmitCmd,
  input  logic              wrHit,
  input  logic [CNT_W-1:0]  frameCount,
  input  logic [FREE_W-1:0] fifoFree,
  output seqStrobe_t        strobe,
  output logic              dmaReq,
  output logic              readyIrq,
  output logic              done
);

  localparam logic [FREE_W-1:0] FULL_BLK = FREE_W'(FIFO_BYTES);
  localparam logic [FREE_W-1:0] WORD_BLK = FREE_W'(FIFO_BYTES / 2);

  logic              active, inBlock, prevEmpty;
  logic [CNT_W-1:0]  remaining, stepBytes;
  logic [FREE_W-1:0] blkLeft, allow, blockBytes, blockWrites;
  logic              startBlk, dmaWr, irqWr, lastOdd, isEmpty, irqNow;

  always_comb begin
    blockBytes  = (remaining >= CNT_W'(FIFO_BYTES)) ? FULL_BLK : remaining[FREE_W-1:0];
    blockWrites = wordMode ? ((blockBytes + FREE_W'(1)) >> 1) : blockBytes;
    startBlk    = dmaMode && active && !inBlock && (fifoFree >= blockBytes);
    dmaWr       = dmaMode && inBlock && wrHit;
    irqWr       = !dmaMode && wrHit && (allow != '0);
    lastOdd     = wordMode && (remaining == CNT_W'(1));
    stepBytes   = (wordMode && !lastOdd) ? CNT_W'(2) : CNT_W'(1);
    isEmpty     = (fifoFree == FULL_BLK);
    irqNow      = !dmaMode && isEmpty && !prevEmpty;
    strobe.fwd      = dmaWr || irqWr;
    strobe.halfWord = dmaWr && lastOdd;
  end

  // DMA frame and block sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      inBlock   <= 1'b0;
      dmaReq    <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
      blkLeft   <= '0;
    end else if (xmitCmd && dmaMode) begin
      remaining <= frameCount;
      active    <= (frameCount != '0);
      done      <= (frameCount == '0);
      inBlock   <= 1'b0;
      dmaReq    <= 1'b0;
    end else begin
      if (startBlk) begin
        inBlock <= 1'b1;
        dmaReq  <= 1'b1;
        blkLeft <= blockWrites;
      end
      if (dmaWr) begin
        blkLeft   <= blkLeft - FREE_W'(1);
        remaining <= remaining - stepBytes;
        if (blkLeft <= FREE_W'(2)) dmaReq  <= 1'b0;
        if (blkLeft == FREE_W'(1)) inBlock <= 1'b0;
        if (remaining == stepBytes) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // interrupt-mode ready pulse and write allowance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEmpty <= 1'b0;
      readyIrq  <= 1'b0;
      allow     <= '0;
    end else begin
      prevEmpty <= isEmpty;
      readyIrq  <= irqNow;
      if (irqNow)     allow <= wordMode ? WORD_BLK : FULL_BLK;
      else if (irqWr) allow <= allow - FREE_W'(1);
    end
  end

endmodule

// File: rtl/txseq_dpath.sv
module txseq_dpath
  import txseq_pkg::*;
#(
  parameter int FIFO_BYTES = 32,
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordMode,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busData,
  input  seqStrobe_t        strobe,
  output logic              wrHit,
  output logic [CNT_W-1:0]  frameCount,
  output logic              fifoWe,
  output logic [15:0]       fifoData,
  output logic [1:0]        fifoByteEn
);

  localparam int HI_W = CNT_W - 8;

  logic [7:0]      countLo;
  logic [HI_W-1:0] countHi;
  logic            loHit, hiHit;

  always_comb begin
    wrHit = busWr && (busAddr < ADDR_W'(FIFO_BYTES));
    loHit = busWr && (busAddr == ADDR_W'(FIFO_BYTES));
    hiHit = busWr && (busAddr == ADDR_W'(FIFO_BYTES + 1));
    frameCount = {countHi, countLo};
    fifoWe     = strobe.fwd;
    fifoData   = busData;
    fifoByteEn = (wordMode && !strobe.halfWord) ? 2'b11 : 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countLo <= '0;
      countHi <= '0;
    end else begin
      if (loHit) countLo <= busData[7:0];
      if (hiHit) countHi <= busData[HI_W-1:0];
    end
  end

endmodule

// File: rtl/txfifo_dma_seq.sv
module txfifo_dma_seq
  import txseq_pkg::*;
#(
  parameter  int FIFO_BYTES = 32,
  parameter  int CNT_W      = 12,
  parameter  int ADDR_W     = 8,
  localparam int FREE_W     = $clog2(FIFO_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaMode,
  input  logic              wordMode,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busData,
  input  logic              xmitCmd,
  input  logic [FREE_W-1:0] fifoFree,
  output logic              dmaReq,
  output logic              readyIrq,
  output logic              done,
  output logic              fifoWe,
  output logic [15:0]       fifoData,
  output logic [1:0]        fifoByteEn
);

  seqStrobe_t       strobe;
  logic             wrHit;
  logic [CNT_W-1:0] frameCount;

  txseq_ctrl #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W), .FREE_W(FREE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .wordMode(wordMode),
    .xmitCmd(xmitCmd), .wrHit(wrHit), .frameCount(frameCount),
    .fifoFree(fifoFree), .strobe(strobe), .dmaReq(dmaReq),
    .readyIrq(readyIrq), .done(done)
  );

  txseq_dpath #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .wordMode(wordMode), .busWr(busWr),
    .busAddr(busAddr), .busData(busData), .strobe(strobe), .wrHit(wrHit),
    .frameCount(frameCount), .fifoWe(fifoWe), .fifoData(fifoData),
    .fifoByteEn(fifoByteEn)
  );

endmodule

// File: rtl/txfifo_dma_seq_chk.sv
module txfifo_dma_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dmaMode,
  input logic       wordMode,
  input logic       dmaReq,
  input logic       readyIrq,
  input logic       done,
  input logic       fifoWe,
  input logic [1:0] fifoByteEn
);

  // R3
  low_byte_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWe |-> fifoByteEn[0]);

  // R4
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyIrq |=> !readyIrq);

  // R8
  done_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && dmaMode) |-> !fifoWe);

  // R8
  done_no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !dmaReq);

  // R9
  half_word_is_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode && wordMode && fifoWe && fifoByteEn == 2'b01) |=> done);

endmodule

bind txfifo_dma_seq txfifo_dma_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .wordMode(wordMode),
  .dmaReq(dmaReq), .readyIrq(readyIrq), .done(done), .fifoWe(fifoWe),
  .fifoByteEn(fifoByteEn)
);

// File: tb/txfifo_dma_seq_tb_top.sv
`timescale 1ns/1ps
module txfifo_dma_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dmaMode = 1'b0, wordMode = 1'b0, busWr = 1'b0, xmitCmd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busData = '0;
  logic [5:0]  fifoFree = '0;
  logic        dmaReq, readyIrq, done, fifoWe;
  logic [15:0] fifoData;
  logic [1:0]  fifoByteEn;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  txfifo_dma_seq dut_i (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .wordMode(wordMode),
    .busWr(busWr), .busAddr(busAddr), .busData(busData), .xmitCmd(xmitCmd),
    .fifoFree(fifoFree), .dmaReq(dmaReq), .readyIrq(readyIrq), .done(done),
    .fifoWe(fifoWe), .fifoData(fifoData), .fifoByteEn(fifoByteEn)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [15:0] data);
    busWr = 1'b1; busAddr = addr; busData = data;
    #1 check("R2", "register write reaches FIFO", int'(fifoWe), 0);
    tick();
    busWr = 1'b0;
  endtask

  task automatic startFrame(input int count, input bit word);
    dmaMode = 1'b1; wordMode = word;
    writeReg(8'h20, 16'(count & 255));
    writeReg(8'h21, 16'(count >> 8));
    xmitCmd = 1'b1;
    tick();
    xmitCmd = 1'b0;
  endtask

  // one accepted DMA write, checking data path, then request level after it
  task automatic dmaWrite(input bit word, inout int rem, input int left);
    int nb;
    nb = (word && rem >= 2) ? 2 : 1;
    busWr = 1'b1; busAddr = 8'((rem * 7) % 32); busData = 16'(16'h5A00 + rem);
    #1;
    check("R10", "block write enable", int'(fifoWe), 1);
    if (word && nb == 1) check("R9", "odd final byte enable", int'(fifoByteEn), 1);
    else check("R3", "byte enable", int'(fifoByteEn), (word ? 3 : 1));
    check("R3", "data passthrough", int'(fifoData), int'(busData));
    tick();
    busWr = 1'b0;
    rem = rem - nb;
    check("R7", "request after write", int'(dmaReq), (left >= 2) ? 1 : 0);
  endtask

  task automatic runFrame(input int count, input bit word);
    int rem;
    fifoFree = 6'd32;
    startFrame(count, word);
    if (count == 0) begin
      check("R8", "zero count done", int'(done), 1);
      tick();
      check("R8", "zero count no request", int'(dmaReq), 0);
      return;
    end
    rem = count;
    while (rem > 0) begin
      int bb, nw;
      bb = (rem > 32) ? 32 : rem;
      nw = word ? (bb + 1) / 2 : bb;
      check("R6", "request low before block", int'(dmaReq), 0);
      tick();
      check("R5", "block request raised", int'(dmaReq), 1);
      for (int i = 1; i <= nw; i++) dmaWrite(word, rem, nw - i);
    end
    check("R8", "done after last write", int'(done), 1);
    tick();
    tick();
    check("R5", "no request after last block", int'(dmaReq), 0);
    busWr = 1'b1; busAddr = 8'h00;
    #1 check("R8", "write ignored while done", int'(fifoWe), 0);
    tick();
    busWr = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "dmaReq reset", int'(dmaReq), 0);
    check("R1", "readyIrq reset", int'(readyIrq), 0);
    check("R1", "done reset", int'(done), 0);
    check("R1", "fifoWe reset", int'(fifoWe), 0);
  endtask

  task automatic fireIrq(input bit word);
    dmaMode = 1'b0; wordMode = word; fifoFree = 6'd0;
    tick(); tick();
    fifoFree = 6'd32;
    tick();
    check("R4", "ready pulse high", int'(readyIrq), 1);
    tick();
    check("R4", "ready pulse ends", int'(readyIrq), 0);
  endtask

  task automatic testIrqMode(input bit word);
    int lim;
    lim = word ? 16 : 32;
    fireIrq(word);
    for (int i = 0; i <= lim; i++) begin
      busWr = 1'b1; busAddr = 8'(i % 32); busData = 16'(i * 3);
      #1;
      check("R4", "allowance", int'(fifoWe), (i < lim) ? 1 : 0);
      if (i < lim) check("R3", "irq byte enable", int'(fifoByteEn), word ? 3 : 1);
      tick();
    end
    busWr = 1'b0;
  endtask

  task automatic testDecode();
    fireIrq(1'b0);
    busWr = 1'b1; busAddr = 8'h40;
    #1 check("R2", "out-of-map write dropped", int'(fifoWe), 0);
    tick();
    busAddr = 8'h1F;
    #1 check("R2", "top of window accepted", int'(fifoWe), 1);
    tick();
    busWr = 1'b0;
  endtask

  task automatic testIdleWrite();
    dmaMode = 1'b1; fifoFree = 6'd32;
    tick();
    busWr = 1'b1; busAddr = 8'h03;
    #1 check("R10", "write outside block dropped", int'(fifoWe), 0);
    tick();
    busWr = 1'b0;
    check("R10", "no request without command", int'(dmaReq), 0);
  endtask

  task automatic testHoldOff();
    int rem;
    fifoFree = 6'd10;
    startFrame(40, 1'b0);
    tick(); tick(); tick();
    check("R6", "held while no room", int'(dmaReq), 0);
    fifoFree = 6'd32;
    tick();
    check("R6", "raised once room", int'(dmaReq), 1);
    rem = 40;
    for (int i = 1; i <= 32; i++) dmaWrite(1'b0, rem, 32 - i);
    fifoFree = 6'd7;
    tick(); tick();
    check("R6", "remainder held at 7 free", int'(dmaReq), 0);
    fifoFree = 6'd8;
    tick();
    check("R6", "remainder raised at exact room", int'(dmaReq), 1);
    for (int i = 1; i <= 8; i++) dmaWrite(1'b0, rem, 8 - i);
    check("R8", "hold frame done", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleWrite();
    testIrqMode(1'b0);
    testIrqMode(1'b1);
    testDecode();
    runFrame(70, 1'b0);
    runFrame(64, 1'b1);
    runFrame(37, 1'b1);
    runFrame(5, 1'b0);
    runFrame(0, 1'b0);
    testHoldOff();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule